// File: doc/BRIEF.md
# Camera Serial Transmitter Control Register File

This block is the register file that sits between a simple 32-bit register bus and the packet and stream logic of a multi-stream camera serial transmitter. Software reads a fixed capability word to learn how many data lanes and streams were built and whether a physical layer is present. It then uses a global control word to enter configuration mode or request a soft reset. It programs a physical-layer configuration word and a wake-up cycle count. For each stream it also programs a data type, a line format (bytes per line and maximum line count) and an input fill-level threshold.

Every programmed field is driven out as a decoded port so that downstream logic needs no decoding of its own. Per-stream settings are protected: they accept writes only while configuration mode is held and no soft reset is pending. A held soft-reset request wipes all stream settings. Each stream's enable output is asserted only in normal operation, and only for a stream with a non-zero line length.

Top module: `camtx_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset every writable register is zero, `rd_data` is zero and every `st_en` bit is low.
- R2: Offset 0x00 is a read-only capability word: bits 2:0 hold NUM_LANES, bit 3 holds HAS_PHY and bits 6:4 hold NUM_STREAMS. All other bits are zero. With the default parameters it reads 0x4C. Writes to it change nothing.
- R3: Offset 0x20 is the control word. Bit 2 is the configuration-mode request and bit 1 is the soft-reset request. Both read back and drive `cfg_mode` and `soft_rst` from the cycle after the write. All other bits read zero, and writing zero leaves both modes.
- R4: Offset 0x28 is a 32-bit physical-layer configuration word driven on `phy_cfg`. Offset 0x2C holds a 16-bit wake-up cycle count in bits 15:0, driven on `wake_cycles`. Its upper bits read zero.
- R5: Stream n's data-type register sits at 0x80 + 8n. It keeps a 6-bit data type in bits 7:2 and reads zero elsewhere. Stream n's type drives `st_dtype[6n+5:6n]`.
- R6: Stream n's format register sits at 0x84 + 8n. Bits 31:16 are bytes per line (`st_bytes[16n+15:16n]`) and bits 15:0 are the maximum line count (`st_lines[16n+15:16n]`).
- R7: Stream n's fill-level register sits at 0x100 + 4n. It keeps bits 4:0 (`st_fill[5n+4:5n]`) and reads zero above them.
- R8: A write to any per-stream register is ignored unless the control word has the configuration-mode bit set and the soft-reset bit clear.
- R9: While the soft-reset bit is set, every per-stream register is cleared on each clock and all `st_en` bits are low. Physical-layer and wake-up registers are kept.
- R10: A read from any offset that is not mapped returns zero. This includes misaligned offsets and stream slots at or above NUM_STREAMS.
- R11: `rd_data` is loaded on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.
- R12: `st_en[n]` is high exactly when both control bits are clear and stream n's bytes-per-line field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| cfg_mode | output | 1 | Configuration mode held |
| soft_rst | output | 1 | Soft reset held |
| phy_cfg | output | 32 | Physical-layer configuration word |
| wake_cycles | output | 16 | Wake-up cycle count |
| st_dtype | output | 6*NUM_STREAMS | Per-stream data type |
| st_bytes | output | 16*NUM_STREAMS | Per-stream bytes per line |
| st_lines | output | 16*NUM_STREAMS | Per-stream maximum line count |
| st_fill | output | 5*NUM_STREAMS | Per-stream fill-level threshold |
| st_en | output | NUM_STREAMS | Per-stream enable |

## Verification
A wrong stored value shows up directly on the decoded field ports in the cycle after the write. On `rd_data` it shows up one edge after a read strobe. A broken write gate or soft-reset clear shows up as a per-stream field that changed, or failed to clear, within one clock. A wrong enable term shows up as an `st_en` bit that is high during configuration mode or soft reset, or for a stream whose line length is zero. A decode error surfaces as a non-zero read of an unmapped offset, or as a write that lands in the wrong stream slot. That slot's field port shows it at once.

// File: rtl/camtx_pkg.sv
// Shared offsets, field positions and the per-stream record type for the
// camera transmitter control register file.
package camtx_pkg;
    localparam int OFF_CAP       = 'h000;
    localparam int OFF_CTRL      = 'h020;
    localparam int OFF_PHY       = 'h028;
    localparam int OFF_WAKE      = 'h02C;
    localparam int OFF_DT_BASE   = 'h080;
    localparam int DT_STRIDE     = 8;
    localparam int FMT_DELTA     = 4;
    localparam int OFF_FILL_BASE = 'h100;
    localparam int FILL_STRIDE   = 4;
    localparam int CTRL_CFG_BIT  = 2;
    localparam int CTRL_SRST_BIT = 1;

    typedef struct packed {
        logic [5:0]  dtype;
        logic [15:0] bpl;
        logic [15:0] lines;
        logic [4:0]  fill;
    } stream_cfg_t;
endpackage

// File: rtl/camtx_addr_dec.sv
// Address decoder: turns a byte offset into one-hot hit lines for every
// mapped register. Assumes exact, word-aligned offsets; anything else misses.
module camtx_addr_dec #(
    parameter int ADDR_W      = 12,
    parameter int NUM_STREAMS = 4
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic                   hit_cap,
    output logic                   hit_ctrl,
    output logic                   hit_phy,
    output logic                   hit_wake,
    output logic [NUM_STREAMS-1:0] hit_dt,
    output logic [NUM_STREAMS-1:0] hit_fmt,
    output logic [NUM_STREAMS-1:0] hit_fill
);
    import camtx_pkg::*;

    // Global register hits.
    always_comb begin
        hit_cap  = (addr == ADDR_W'(OFF_CAP));
        hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
        hit_phy  = (addr == ADDR_W'(OFF_PHY));
        hit_wake = (addr == ADDR_W'(OFF_WAKE));
    end

    // One set of comparators per stream slot.
    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] A_DT   = ADDR_W'(OFF_DT_BASE + i * DT_STRIDE);
        localparam logic [ADDR_W-1:0] A_FMT  = ADDR_W'(OFF_DT_BASE + i * DT_STRIDE + FMT_DELTA);
        localparam logic [ADDR_W-1:0] A_FILL = ADDR_W'(OFF_FILL_BASE + i * FILL_STRIDE);
        assign hit_dt[i]   = (addr == A_DT);
        assign hit_fmt[i]  = (addr == A_FMT);
        assign hit_fill[i] = (addr == A_FILL);
    end
endmodule

// File: rtl/camtx_stream_reg.sv
// Storage for one stream's settings. A held clear wins over any write.
// Assumes the write enables are already gated by the mode checks in the top.
module camtx_stream_reg (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wen_dt,
    input  logic                   wen_fmt,
    input  logic                   wen_fill,
    input  logic [31:0]            wdata,
    output camtx_pkg::stream_cfg_t cfg_q
);
    // Load or clear the stream fields.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cfg_q <= '0;
        end else begin
            if (wen_dt)   cfg_q.dtype <= wdata[7:2];
            if (wen_fmt)  begin
                cfg_q.bpl   <= wdata[31:16];
                cfg_q.lines <= wdata[15:0];
            end
            if (wen_fill) cfg_q.fill  <= wdata[4:0];
        end
    end
endmodule

// File: rtl/camtx_rd_mux.sv
// Read multiplexer: forms the read word for the addressed register, or zero
// when nothing is hit. Assumes at most one hit line is high.
module camtx_rd_mux #(
    parameter int NUM_STREAMS = 4
) (
    input  logic                                     hit_cap,
    input  logic                                     hit_ctrl,
    input  logic                                     hit_phy,
    input  logic                                     hit_wake,
    input  logic [NUM_STREAMS-1:0]                   hit_dt,
    input  logic [NUM_STREAMS-1:0]                   hit_fmt,
    input  logic [NUM_STREAMS-1:0]                   hit_fill,
    input  logic [31:0]                              cap_word,
    input  logic                                     cfg_q,
    input  logic                                     srst_q,
    input  logic [31:0]                              phy_q,
    input  logic [15:0]                              wake_q,
    input  camtx_pkg::stream_cfg_t [NUM_STREAMS-1:0] st_q,
    output logic [31:0]                              rdata
);
    // Select the word for the hit register.
    always_comb begin
        rdata = '0;
        if (hit_cap)  rdata = cap_word;
        if (hit_ctrl) rdata = {29'b0, cfg_q, srst_q, 1'b0};
        if (hit_phy)  rdata = phy_q;
        if (hit_wake) rdata = {16'b0, wake_q};
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (hit_dt[i])   rdata = {24'b0, st_q[i].dtype, 2'b0};
            if (hit_fmt[i])  rdata = {st_q[i].bpl, st_q[i].lines};
            if (hit_fill[i]) rdata = {27'b0, st_q[i].fill};
        end
    end
endmodule

// File: rtl/camtx_ctrl_regs.sv
// Control register file of a multi-stream camera serial transmitter.
// Holds capability, control, physical-layer and per-stream registers and
// drives their decoded fields. Assumes single-cycle bus strobes and
// NUM_STREAMS, NUM_LANES in 1..4 so they fit the 3-bit capability fields.
module camtx_ctrl_regs #(
    parameter int ADDR_W      = 12,
    parameter int NUM_STREAMS = 4,
    parameter int NUM_LANES   = 4,
    parameter bit HAS_PHY     = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [31:0]               wr_data,
    input  logic                      rd_en,
    output logic [31:0]               rd_data,
    output logic                      cfg_mode,
    output logic                      soft_rst,
    output logic [31:0]               phy_cfg,
    output logic [15:0]               wake_cycles,
    output logic [6*NUM_STREAMS-1:0]  st_dtype,
    output logic [16*NUM_STREAMS-1:0] st_bytes,
    output logic [16*NUM_STREAMS-1:0] st_lines,
    output logic [5*NUM_STREAMS-1:0]  st_fill,
    output logic [NUM_STREAMS-1:0]    st_en
);
    import camtx_pkg::*;

    localparam logic [31:0] CAP_WORD =
        {25'b0, 3'(NUM_STREAMS), HAS_PHY, 3'(NUM_LANES)};

    logic                   hit_cap, hit_ctrl, hit_phy, hit_wake;
    logic [NUM_STREAMS-1:0] hit_dt, hit_fmt, hit_fill;
    logic                   cfg_q, srst_q;
    logic [31:0]            phy_q;
    logic [15:0]            wake_q;
    logic [31:0]            rdata_nxt;
    logic                   st_wr_ok;
    stream_cfg_t [NUM_STREAMS-1:0] st_q;

    camtx_addr_dec #(.ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS)) i_dec (
        .addr     (addr),
        .hit_cap  (hit_cap),
        .hit_ctrl (hit_ctrl),
        .hit_phy  (hit_phy),
        .hit_wake (hit_wake),
        .hit_dt   (hit_dt),
        .hit_fmt  (hit_fmt),
        .hit_fill (hit_fill)
    );

    // Global control word: configuration-mode and soft-reset requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= 1'b0;
            srst_q <= 1'b0;
        end else if (wr_en && hit_ctrl) begin
            cfg_q  <= wr_data[CTRL_CFG_BIT];
            srst_q <= wr_data[CTRL_SRST_BIT];
        end
    end

    // Physical-layer configuration and wake-up count, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q  <= '0;
            wake_q <= '0;
        end else if (wr_en) begin
            if (hit_phy)  phy_q  <= wr_data;
            if (hit_wake) wake_q <= wr_data[15:0];
        end
    end

    // Per-stream writes pass only in configuration mode without soft reset.
    assign st_wr_ok = wr_en && cfg_q && !srst_q;

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
        camtx_stream_reg i_sreg (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (srst_q),
            .wen_dt   (st_wr_ok && hit_dt[i]),
            .wen_fmt  (st_wr_ok && hit_fmt[i]),
            .wen_fill (st_wr_ok && hit_fill[i]),
            .wdata    (wr_data),
            .cfg_q    (st_q[i])
        );
        assign st_dtype[6*i +: 6]  = st_q[i].dtype;
        assign st_bytes[16*i +: 16] = st_q[i].bpl;
        assign st_lines[16*i +: 16] = st_q[i].lines;
        assign st_fill[5*i +: 5]   = st_q[i].fill;
        assign st_en[i] = !cfg_q && !srst_q && (st_q[i].bpl != '0);
    end

    camtx_rd_mux #(.NUM_STREAMS(NUM_STREAMS)) i_rmux (
        .hit_cap  (hit_cap),
        .hit_ctrl (hit_ctrl),
        .hit_phy  (hit_phy),
        .hit_wake (hit_wake),
        .hit_dt   (hit_dt),
        .hit_fmt  (hit_fmt),
        .hit_fill (hit_fill),
        .cap_word (CAP_WORD),
        .cfg_q    (cfg_q),
        .srst_q   (srst_q),
        .phy_q    (phy_q),
        .wake_q   (wake_q),
        .st_q     (st_q),
        .rdata    (rdata_nxt)
    );

    // Registered read port, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rdata_nxt;
    end

    assign cfg_mode    = cfg_q;
    assign soft_rst    = srst_q;
    assign phy_cfg     = phy_q;
    assign wake_cycles = wake_q;
endmodule

// File: rtl/camtx_ctrl_regs_chk.sv
// Property checker for camtx_ctrl_regs, attached by bind. Observes ports only.
module camtx_ctrl_regs_chk #(
    parameter int ADDR_W      = 12,
    parameter int NUM_STREAMS = 4,
    parameter int NUM_LANES   = 4,
    parameter bit HAS_PHY     = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic                      wr_en,
    input logic [31:0]               wr_data,
    input logic                      rd_en,
    input logic [31:0]               rd_data,
    input logic                      cfg_mode,
    input logic                      soft_rst,
    input logic [31:0]               phy_cfg,
    input logic [15:0]               wake_cycles,
    input logic [6*NUM_STREAMS-1:0]  st_dtype,
    input logic [16*NUM_STREAMS-1:0] st_bytes,
    input logic [16*NUM_STREAMS-1:0] st_lines,
    input logic [5*NUM_STREAMS-1:0]  st_fill,
    input logic [NUM_STREAMS-1:0]    st_en
);
    localparam logic [31:0] EXP_CAP =
        {25'b0, 3'(NUM_STREAMS), HAS_PHY, 3'(NUM_LANES)};

    // R2: the capability read returns the built-in parameters.
    p_cap_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(0)) |=> rd_data == EXP_CAP);

    // R3: a control write shows on the mode outputs one cycle later.
    p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h20)) |=>
        (cfg_mode == $past(wr_data[2]) && soft_rst == $past(wr_data[1])));

    // R8: outside configuration mode the stream fields cannot change.
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && !soft_rst) |=>
        ($stable(st_dtype) && $stable(st_bytes) && $stable(st_lines) && $stable(st_fill)));

    // R9: a held soft reset empties every stream field.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_dtype == '0 && st_bytes == '0 && st_lines == '0 && st_fill == '0));

    // R9: no stream is enabled during soft reset.
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> st_en == '0);

    // R10: an unmapped offset reads as zero.
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'('h04)) |=> rd_data == '0);

    // R11: read data holds without a read strobe.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R12: enables only appear in normal operation.
    p_en_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en != '0) |-> (!cfg_mode && !soft_rst));
endmodule

bind camtx_ctrl_regs camtx_ctrl_regs_chk #(
    .ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS),
    .NUM_LANES(NUM_LANES), .HAS_PHY(HAS_PHY)
) i_chk (.*);

// File: tb/test_camtx_ctrl_regs.sv
// Self-checking bench: a vector table walked by one loop, then directed
// checks for reset, stream enables, soft reset and read hold.
module test_camtx_ctrl_regs;
    localparam int NS = 4;

    typedef struct packed {
        logic        rd;
        logic [7:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd2,  12'h000, 32'h0000004C},
        '{1'b0, 8'd2,  12'h000, 32'hFFFFFFFF},
        '{1'b1, 8'd2,  12'h000, 32'h0000004C},
        '{1'b0, 8'd8,  12'h080, 32'h000000FF},
        '{1'b1, 8'd8,  12'h080, 32'h00000000},
        '{1'b0, 8'd3,  12'h020, 32'hFFFFFFFF},
        '{1'b1, 8'd3,  12'h020, 32'h00000006},
        '{1'b0, 8'd3,  12'h020, 32'h00000004},
        '{1'b1, 8'd3,  12'h020, 32'h00000004},
        '{1'b0, 8'd5,  12'h080, 32'hFFFFFFFF},
        '{1'b1, 8'd5,  12'h080, 32'h000000FC},
        '{1'b0, 8'd6,  12'h084, 32'h12345678},
        '{1'b1, 8'd6,  12'h084, 32'h12345678},
        '{1'b0, 8'd6,  12'h09C, 32'hABCD0010},
        '{1'b1, 8'd6,  12'h09C, 32'hABCD0010},
        '{1'b0, 8'd7,  12'h10C, 32'hFFFFFFFF},
        '{1'b1, 8'd7,  12'h10C, 32'h0000001F},
        '{1'b0, 8'd4,  12'h028, 32'hDEADBEEF},
        '{1'b1, 8'd4,  12'h028, 32'hDEADBEEF},
        '{1'b0, 8'd4,  12'h02C, 32'hFFFF1234},
        '{1'b1, 8'd4,  12'h02C, 32'h00001234},
        '{1'b1, 8'd10, 12'h0A0, 32'h00000000},
        '{1'b1, 8'd10, 12'h004, 32'h00000000},
        '{1'b1, 8'd10, 12'h110, 32'h00000000},
        '{1'b1, 8'd10, 12'h082, 32'h00000000},
        '{1'b0, 8'd8,  12'h020, 32'h00000000},
        '{1'b0, 8'd8,  12'h084, 32'h00000000},
        '{1'b1, 8'd8,  12'h084, 32'h12345678}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      addr = '0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             rd_en = 1'b0;
    logic [31:0]      rd_data;
    logic             cfg_mode, soft_rst;
    logic [31:0]      phy_cfg;
    logic [15:0]      wake_cycles;
    logic [6*NS-1:0]  st_dtype;
    logic [16*NS-1:0] st_bytes, st_lines;
    logic [5*NS-1:0]  st_fill;
    logic [NS-1:0]    st_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    camtx_ctrl_regs #(.ADDR_W(12), .NUM_STREAMS(NS), .NUM_LANES(4), .HAS_PHY(1'b1)) i_camtx_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cfg_mode(cfg_mode), .soft_rst(soft_rst),
        .phy_cfg(phy_cfg), .wake_cycles(wake_cycles), .st_dtype(st_dtype),
        .st_bytes(st_bytes), .st_lines(st_lines), .st_fill(st_fill), .st_en(st_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", 64'(rd_data), 64'h0);
        chk("R1 modes", 64'({cfg_mode, soft_rst}), 64'h0);
        chk("R1 st_en", 64'(st_en), 64'h0);
        chk("R1 phy_cfg", 64'(phy_cfg), 64'h0);
        chk("R1 st_bytes", st_bytes, 64'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rd) begin
                bus_rd(VEC[k].addr, rv);
                chk($sformatf("R%0d vector %0d", VEC[k].req, k), 64'(rv), 64'(VEC[k].data));
            end else begin
                bus_wr(VEC[k].addr, VEC[k].data);
            end
        end

        // Field outputs after the table (normal mode, streams 0 and 3 have lines).
        chk("R12 st_en normal", 64'(st_en), 64'h9);
        chk("R3 cfg_mode cleared", 64'(cfg_mode), 64'h0);
        chk("R4 phy_cfg port", 64'(phy_cfg), 64'hDEADBEEF);
        chk("R4 wake port", 64'(wake_cycles), 64'h1234);
        chk("R5 st_dtype stream0", 64'(st_dtype[5:0]), 64'h3F);
        chk("R6 st_bytes stream3", 64'(st_bytes[63:48]), 64'hABCD);
        chk("R6 st_lines stream0", 64'(st_lines[15:0]), 64'h5678);
        chk("R7 st_fill stream3", 64'(st_fill[19:15]), 64'h1F);

        // R12: configuration mode drops every enable.
        bus_wr(12'h020, 32'h4);
        chk("R12 st_en in cfg", 64'(st_en), 64'h0);

        // R9: soft reset clears streams and blocks writes.
        bus_wr(12'h020, 32'h6);
        chk("R9 st_en in srst", 64'(st_en), 64'h0);
        bus_wr(12'h080, 32'hFC);
        bus_rd(12'h080, rv);
        chk("R9 dtype write blocked", 64'(rv), 64'h0);
        bus_rd(12'h084, rv);
        chk("R9 fmt cleared", 64'(rv), 64'h0);
        bus_rd(12'h09C, rv);
        chk("R9 fmt3 cleared", 64'(rv), 64'h0);
        chk("R9 phy kept", 64'(phy_cfg), 64'hDEADBEEF);
        bus_wr(12'h020, 32'h0);
        chk("R9 st_en stays low", 64'(st_en), 64'h0);

        // R11: read data holds when no strobe.
        bus_rd(12'h028, rv);
        @(negedge clk);
        addr = 12'h000;
        @(negedge clk);
        chk("R11 rd_data hold", 64'(rd_data), 64'hDEADBEEF);

        // R1: reset in the middle of a run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 phy after reset", 64'(phy_cfg), 64'h0);
        chk("R1 rd_data after reset", 64'(rd_data), 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule